// File: doc/BRIEF.md
# Reloadable Transfer Length Counter

This block holds the byte count for a DMA transfer. Software programs the count one byte at a time into a write-side image that the live counter does not see. The count moves into the live counter only when a command arrives with its DMA flag set. A start-transfer command that carries the DMA flag also arms the counter. The armed length is the smaller of the programmed count and the data left in the current bus phase. A programmed count of zero stands for 65536 bytes.

While a transfer runs, each byte strobe takes one off the live count, and the count can be read back at any time. When the count reaches zero, the transfer-active flag drops and the terminal-count bit rises. The high count byte has one special rule: until software first writes it after reset, a read of it returns a fixed identity byte, which lets a driver tell this part from its relatives. The DMA engine and the memory side are outside this block.

Top module: `xfer_count24`

## Requirements
- R1: After reset the live count is zero, `tc` and `busy` are low, and the identity flag is cleared.
- R2: A register write to index 0, 1 or 2 stores `reg_wdata` in the write image at count bits 7:0, 15:8 or 23:16. It does not change the live count. A write to index 3 changes nothing.
- R3: Any register write to index 0, 1 or 2 clears `tc` on the next edge.
- R4: A command with `cmd_dma`=1 and `cmd_start`=0 copies the whole write image into the live count. A command with `cmd_dma`=0 leaves the live count unchanged and starts nothing, even with `cmd_start`=1. Every command ends a transfer that is in progress.
- R5: A command with `cmd_dma`=1 and `cmd_start`=1 loads the live count with min(E, `phase_len`), where E is the write image, or 65536 when the image is zero. If that length is non-zero it sets `busy` and clears `tc`.
- R6: While `busy` is high, each `xfer_stb` lowers the live count by exactly one. While `busy` is low, `xfer_stb` is ignored.
- R7: On the edge where the count reaches zero, `busy` falls and `tc` rises, and the count reads zero. A start whose length is zero sets `tc` at once without raising `busy`. `busy` and `tc` are never high together.
- R8: A read at index 2 returns `CHIP_ID` until index 2 has been written since reset; after that it returns live count bits 23:16. Indexes 0 and 1 read live bits 7:0 and 15:8, and index 3 reads zero.
- R9: When the final strobe and a count-register write fall in the same cycle, `tc` ends high. When a command and a strobe fall in the same cycle, the command wins and the strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational readback of the indexed register |
| cmd_wr | input | 1 | Command strobe |
| cmd_dma | input | 1 | DMA flag carried by the command |
| cmd_start | input | 1 | Command is start-transfer |
| phase_len | input | 17 | Data remaining in the current phase |
| xfer_stb | input | 1 | One byte moved |
| count_out | output | 24 | Live count |
| busy | output | 1 | Transfer in progress |
| tc | output | 1 | Terminal count reached |

## Verification
Two pairs of actions can land on the same edge. The first pair is the strobe that takes the count to zero and a write to a count register, which clears `tc`. The second pair is a command and a byte strobe. The bench drives each pair in one cycle and uses the R9 priorities in its own model: completion beats the clear, and the command beats the strobe. It then compares `tc`, `busy`, the count and the readback with the model on the following clock.

// File: rtl/xfer_count24.sv
module xfer_count24 #(
  parameter int          NBYTES   = 3,
  parameter int          PHASE_W  = 17,
  parameter int          ZERO_LEN = 65536,
  parameter logic [7:0]  CHIP_ID  = 8'h5C
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_addr,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  input  logic                 cmd_wr,
  input  logic                 cmd_dma,
  input  logic                 cmd_start,
  input  logic [PHASE_W-1:0]   phase_len,
  input  logic                 xfer_stb,
  output logic [8*NBYTES-1:0]  count_out,
  output logic                 busy,
  output logic                 tc
);
  localparam int CW = 8 * NBYTES;
  localparam int LW = ((CW > PHASE_W) ? CW : PHASE_W) + 1;
  localparam logic [1:0] TOP_IDX = 2'(NBYTES - 1);

  logic [CW-1:0] image_q, live_q;
  logic          busy_q, tc_q, top_seen_q;

  logic          cnt_wr, last_stb, dma_start;
  logic [LW-1:0] eff_len, ph_len, arm_len;

  assign cnt_wr    = reg_wr && (reg_addr < 2'(NBYTES));
  assign last_stb  = busy_q && xfer_stb && !cmd_wr && (live_q == CW'(1));
  assign dma_start = cmd_wr && cmd_dma && cmd_start;
  assign eff_len   = (image_q == '0) ? LW'(ZERO_LEN) : LW'(image_q);
  assign ph_len    = LW'(phase_len);
  assign arm_len   = (eff_len < ph_len) ? eff_len : ph_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      image_q    <= '0;
      live_q     <= '0;
      busy_q     <= 1'b0;
      tc_q       <= 1'b0;
      top_seen_q <= 1'b0;
    end else begin
      if (reg_wr) begin
        for (int i = 0; i < NBYTES; i++)
          if (reg_addr == 2'(i)) image_q[8*i +: 8] <= reg_wdata;
        if (reg_addr == TOP_IDX) top_seen_q <= 1'b1;
      end

      if (cmd_wr) begin
        busy_q <= 1'b0;
        if (cmd_dma && !cmd_start) live_q <= image_q;
        if (dma_start) begin
          live_q <= CW'(arm_len);
          busy_q <= (arm_len != '0);
        end
      end else if (busy_q && xfer_stb) begin
        live_q <= live_q - CW'(1);
        if (last_stb) busy_q <= 1'b0;
      end

      if (dma_start)     tc_q <= (arm_len == '0);
      else if (last_stb) tc_q <= 1'b1;
      else if (cnt_wr)   tc_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    for (int i = 0; i < NBYTES; i++)
      if (reg_addr == 2'(i)) reg_rdata = live_q[8*i +: 8];
    if (reg_addr == TOP_IDX && !top_seen_q) reg_rdata = CHIP_ID;
  end

  assign count_out = live_q;
  assign busy      = busy_q;
  assign tc        = tc_q;

  // R3: a count write without a same-cycle completion or start leaves tc low
  p_tc_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr && !cmd_wr && !(busy && xfer_stb && count_out == CW'(1)) |=> !tc);

  // R4: DMA reload without start copies the write image
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && cmd_dma && !cmd_start |=> count_out == $past(image_q));

  // R6: strobes decrement while busy, and nothing moves while idle
  p_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && xfer_stb && !cmd_wr |=> count_out == $past(count_out) - CW'(1));
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !cmd_wr |=> $stable(count_out));

  // R7: busy and tc are exclusive; busy ending by strobe leaves zero and tc
  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && tc));
  p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && xfer_stb && !cmd_wr && count_out == CW'(1) |=> tc && count_out == '0);

  // R8: once the top byte is written the identity stays hidden until reset
  p_seen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    top_seen_q |=> top_seen_q);
endmodule

// File: tb/xfer_count24_tb_top.sv
module xfer_count24_tb_top;
  localparam logic [7:0] ID = 8'h5C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        cmd_wr = 1'b0, cmd_dma = 1'b0, cmd_start = 1'b0;
  logic [16:0] phase_len = 17'd0;
  logic        xfer_stb = 1'b0;
  logic [23:0] count_out;
  logic        busy, tc;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  int m_img, m_live;
  bit m_busy, m_tc, m_seen;

  always #5 clk = ~clk;

  xfer_count24 dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_wr(cmd_wr),
    .cmd_dma(cmd_dma), .cmd_start(cmd_start), .phase_len(phase_len),
    .xfer_stb(xfer_stb), .count_out(count_out), .busy(busy), .tc(tc)
  );

  function automatic int exp_rd(input int a);
    case (a)
      0: return m_live & 255;
      1: return (m_live >> 8) & 255;
      2: return m_seen ? ((m_live >> 16) & 255) : int'(ID);
      default: return 0;
    endcase
  endfunction

  task automatic compare(input string tag);
    vectors++;
    if (int'(count_out) != m_live || busy != m_busy || tc != m_tc ||
        int'(reg_rdata) != exp_rd(int'(reg_addr))) begin
      miscompares++;
      $display("FAIL %s: count=%h busy=%b tc=%b rd=%h expected count=%h busy=%b tc=%b rd=%h",
               tag, count_out, busy, tc, reg_rdata, m_live[23:0], m_busy, m_tc,
               exp_rd(int'(reg_addr)));
    end
  endtask

  task automatic step(input bit we, input int a, input int wd,
                      input bit ce, input bit cd, input bit cs,
                      input bit st, input int pl, input string tag);
    int e, len;
    reg_wr = we; reg_addr = 2'(a); reg_wdata = 8'(wd);
    cmd_wr = ce; cmd_dma = cd; cmd_start = cs; xfer_stb = st;
    phase_len = 17'(pl);
    if (we && a < 3) begin
      m_img = (m_img & ~(255 << (8*a))) | ((wd & 255) << (8*a));
      m_tc = 0;
      if (a == 2) m_seen = 1;
    end
    if (ce) begin
      m_busy = 0;
      if (cd && !cs) m_live = old_img;
      if (cd && cs) begin
        e = (old_img == 0) ? 65536 : old_img;
        len = (e < pl) ? e : pl;
        m_live = len;
        m_busy = (len != 0);
        m_tc = (len == 0);
      end
    end else if (m_busy && st) begin
      m_live = m_live - 1;
      if (m_live == 0) begin m_busy = 0; m_tc = 1; end
    end
    @(posedge clk); #2;
    compare(tag);
    @(negedge clk);
    reg_wr = 0; cmd_wr = 0; cmd_dma = 0; cmd_start = 0; xfer_stb = 0;
  endtask

  int old_img;
  task automatic go(input bit we, input int a, input int wd,
                    input bit ce, input bit cd, input bit cs,
                    input bit st, input int pl, input string tag);
    old_img = m_img;
    step(we, a, wd, ce, cd, cs, st, pl, tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk); rst_n = 0;
    m_img = 0; m_live = 0; m_busy = 0; m_tc = 0; m_seen = 0;
    @(posedge clk); #2;
    reg_addr = 2'd2; #1;
    compare(tag);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    do_reset("R1 reset state, id readback");
    go(0,0,0, 0,0,0, 0,0, "R1 low byte after reset");
    // R2: write image, live count untouched; index 3 ignored
    go(1,0,8'h34, 0,0,0, 0,0, "R2 write low");
    go(1,1,8'h12, 0,0,0, 0,0, "R2 write mid");
    go(0,2,0, 0,0,0, 0,0, "R8 id before top write");
    go(1,3,8'hFF, 0,0,0, 0,0, "R2 index 3 ignored");
    go(1,2,8'h00, 0,0,0, 0,0, "R8 top written, live high byte");
    // R4: reload on DMA command, nothing on non-DMA start
    go(0,0,0, 1,1,0, 0,0, "R4 dma reload low");
    go(0,1,0, 0,0,0, 0,0, "R4 dma reload mid");
    go(1,0,8'h05, 0,0,0, 0,0, "R2 write low 5");
    go(1,1,8'h00, 0,0,0, 0,0, "R2 write mid 0");
    go(0,0,0, 1,0,1, 0,100, "R4 non-dma start ignored");
    // R5/R6/R7: run length 5 to terminal count
    go(0,0,0, 1,1,1, 0,100, "R5 start len 5");
    go(0,0,0, 0,0,0, 1,0, "R6 strobe");
    go(0,0,0, 0,0,0, 0,0, "R6 no strobe hold");
    for (int i = 0; i < 4; i++) go(0,0,0, 0,0,0, 1,0, "R7 strobe to zero");
    go(0,0,0, 0,0,0, 1,0, "R6 idle strobe ignored");
    go(1,3,8'h01, 0,0,0, 0,0, "R3 index 3 keeps tc");
    go(1,1,8'h00, 0,0,0, 0,0, "R3 count write clears tc");
    // R5: zero image means 65536, clipped by phase
    go(1,0,8'h00, 0,0,0, 0,0, "R2 clear low");
    go(0,2,0, 1,1,1, 0,17'h1FFFF, "R5 zero count is 65536");
    for (int i = 0; i < 3; i++) go(0,1,0, 0,0,0, 1,0, "R6 long run strobe");
    go(0,0,0, 1,0,0, 1,0, "R4 command ends transfer, R9 strobe lost");
    // R5 min and R9 completion versus write
    go(1,1,8'h03, 0,0,0, 0,0, "R2 mid 3");
    go(0,0,0, 1,1,1, 0,3, "R5 phase limits length");
    go(0,0,0, 0,0,0, 1,0, "R6 strobe");
    go(0,0,0, 0,0,0, 1,0, "R6 strobe");
    go(1,0,8'h04, 0,0,0, 1,0, "R9 final strobe beats count write");
    go(0,0,0, 1,1,1, 0,0, "R7 zero length sets tc at once");
    go(1,1,8'h00, 0,0,0, 0,0, "R3 clear tc");
    go(0,0,0, 1,1,1, 1,50, "R9 start beats strobe");
    go(0,0,0, 0,0,0, 1,0, "R6 strobe after start");
    do_reset("R8 reset restores id");
    go(0,0,0, 0,0,0, 1,0, "R1 idle after reset");
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule